// File: doc/BRIEF.md
# UART Data Buffer with Selectable FIFO Depth

This block holds the bytes that pass between a byte-wide register port and a UART's shift registers. It has one queue in each direction. A received-byte strobe fills the receive queue, and a read of the data register drains it. A write of the data register fills the transmit queue. The queue hands its head byte to the transmit shifter whenever the shifter reports that it is ready.

Each queue has an enable bit. When the bit is clear, the queue acts as a one-word holding buffer. When the bit is set, the queue uses its full hardware depth, which is a build-time parameter. A read-only code reports that depth, and the code does not change with the enable bit.

Software can discard the stored words of either queue with a command bit. A command never disturbs a byte that the transmit shifter has already taken. Three error events set sticky flags: a receive overrun, a transmit overflow and a receive underflow. Each flag can raise its own interrupt line.

Top module: `uart_fifo_buf`

Register map, selected by `reg_addr`:
- 0: data register. A write pushes a byte into the transmit queue. A read pops a byte from the receive queue.
- 1: mode register. Bit 7 is the transmit queue enable. Bits 6:4 are the transmit depth code (read-only). Bit 3 is the receive queue enable. Bits 2:0 are the receive depth code (read-only).
- 2: queue control register. Bit 7 is the transmit flush command and bit 6 is the receive flush command; both are write-only and read as 0. Bits 2, 1 and 0 are the interrupt enables for receive overrun, transmit overflow and receive underflow. Bits 7:3 read as 0.
- 3: status register. Bit 2 is the receive overrun flag, bit 1 the transmit overflow flag and bit 0 the receive underflow flag. Writing 1 to a bit clears that flag.

Read data is registered and appears on the cycle after the `reg_rd` strobe.

## Requirements
- R1: After reset, the queue control register and the status register read 0x00, both enables read 0, all interrupt lines are low and `tx_load` is low.
- R2: With the receive enable clear, the receive queue holds one word. A second received byte before a read is dropped and sets the overrun flag (status bit 2). The stored byte still reads back.
- R3: The depth code maps 1, 4, 8, 16, 32, 64 and 128 words to 000 through 110. It reads the same whether the enable is set or clear. With the default depths (receive 16, transmit 8), the mode register reads 0x23 when both queues are disabled and 0xAB when both are enabled.
- R4: With the receive enable set, the queue keeps up to its full depth in arrival order. A byte that arrives when the queue is full is dropped, the stored bytes are kept, and the overrun flag is set.
- R5: A data read from an empty receive queue returns the last byte read and sets the underflow flag (status bit 0).
- R6: Bytes written to the data register leave on `tx_byte` in write order. `tx_load` pulses once per byte, in the cycle after a cycle in which `tx_ready` was high and the queue was not empty.
- R7: A data write to a full transmit queue is dropped and sets the transmit overflow flag (status bit 1).
- R8: Writing 1 to control bit 7 empties the transmit queue in one clock. The byte already on `tx_byte` stays unchanged, and no further load happens until new data is written.
- R9: Writing 1 to control bit 6 empties the receive queue. Writing 0 to the flush bits discards nothing.
- R10: Control bits 7:3 read back as 0. Bits 2:0 read back the written interrupt enables.
- R11: Each interrupt line is high exactly when its sticky flag and its enable bit are both set.
- R12: The flags stay set until a 1 is written to their status bit. Writing 0 leaves them set.
- R13: If a receive flush and a received byte land in the same cycle, the flush wins: the queue ends up empty and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rx_strobe | input | 1 | Received byte valid (one cycle) |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmit shifter can accept a byte |
| tx_load | output | 1 | Byte handed to the shifter this cycle |
| tx_byte | output | 8 | Byte for the shifter, held until the next load |
| irq_rx_ovf | output | 1 | Receive overrun interrupt |
| irq_tx_ovf | output | 1 | Transmit overflow interrupt |
| irq_rx_udf | output | 1 | Receive underflow interrupt |

## Verification
The hardest case to reach from the ports is a flush that coincides with another event. The bench creates it by driving the receive strobe and the flush write on the same clock edge, then reading the status and data registers to show that the queue is empty and no overrun was flagged. It also sets up a transmit flush while a byte is already held on `tx_byte`. For this, it releases `tx_ready` for exactly one cycle, queues further bytes and flushes. It then re-arms `tx_ready`, so any stray load is caught by the scoreboard.

// File: rtl/uart_fifo_buf_pkg.sv
package uart_fifo_buf_pkg;
  localparam int unsigned DW = 8;

  // Encode a supported depth as its read-only size code
  function automatic logic [2:0] depth_code(input int unsigned d);
    case (d)
      1:       return 3'd0;
      4:       return 3'd1;
      8:       return 3'd2;
      16:      return 3'd3;
      32:      return 3'd4;
      64:      return 3'd5;
      128:     return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  typedef struct packed {
    logic rx_ovf;
    logic tx_ovf;
    logic rx_udf;
  } err_flags_t;
endpackage

// File: rtl/uart_fifo_buf_q.sv
module uart_fifo_buf_q #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic do_push, do_pop;

  assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf
  import uart_fifo_buf_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned TX_DEPTH = 8,
  localparam int unsigned RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int unsigned TX_CW   = $clog2(TX_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_strobe,
  input  logic [7:0] rx_byte,
  input  logic       tx_ready,
  output logic       tx_load,
  output logic [7:0] tx_byte,
  output logic       irq_rx_ovf,
  output logic       irq_tx_ovf,
  output logic       irq_rx_udf
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam logic [2:0] RX_CODE = depth_code(RX_DEPTH);
  localparam logic [2:0] TX_CODE = depth_code(TX_DEPTH);

  logic rx_en, tx_en;
  logic [2:0] irq_en;
  err_flags_t flags;
  logic [7:0] rx_last;

  logic wr_data, rd_data, wr_mode, wr_ctrl, wr_stat;
  logic rx_flush, tx_flush, tx_fire;
  logic [7:0] rx_head, tx_head;
  logic [RX_CW-1:0] rx_count;
  logic [TX_CW-1:0] tx_count;
  logic rx_full, rx_empty, tx_full, tx_empty;

  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign rd_data  = reg_rd && (reg_addr == A_DATA);
  assign wr_mode  = reg_wr && (reg_addr == A_MODE);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign rx_flush = wr_ctrl && reg_wdata[6];
  assign tx_flush = wr_ctrl && reg_wdata[7];
  assign tx_fire  = tx_ready && !tx_empty && !tx_flush;

  uart_fifo_buf_q #(.DEPTH(RX_DEPTH), .DW(DW)) u_rxq (
    .clk, .rst, .fifo_en(rx_en), .flush(rx_flush),
    .push(rx_strobe), .push_data(rx_byte), .pop(rd_data),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  uart_fifo_buf_q #(.DEPTH(TX_DEPTH), .DW(DW)) u_txq (
    .clk, .rst, .fifo_en(tx_en), .flush(tx_flush),
    .push(wr_data), .push_data(reg_wdata), .pop(tx_fire),
    .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
      irq_en <= '0;
    end else begin
      if (wr_mode) begin
        tx_en <= reg_wdata[7];
        rx_en <= reg_wdata[3];
      end
      if (wr_ctrl) irq_en <= reg_wdata[2:0];
    end
  end

  // sticky error flags: set beats clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      flags.rx_ovf <= (rx_strobe && rx_full && !rx_flush) ||
                      (flags.rx_ovf && !(wr_stat && reg_wdata[2]));
      flags.tx_ovf <= (wr_data && tx_full) ||
                      (flags.tx_ovf && !(wr_stat && reg_wdata[1]));
      flags.rx_udf <= (rd_data && rx_empty && !rx_flush) ||
                      (flags.rx_udf && !(wr_stat && reg_wdata[0]));
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      rx_last   <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_DATA: begin
          if (!rx_empty && !rx_flush) begin
            reg_rdata <= rx_head;
            rx_last   <= rx_head;
          end else begin
            reg_rdata <= rx_last;
          end
        end
        A_MODE:  reg_rdata <= {tx_en, TX_CODE, rx_en, RX_CODE};
        A_CTRL:  reg_rdata <= {5'b0, irq_en};
        default: reg_rdata <= {5'b0, flags};
      endcase
    end
  end

  // transmit shifter handoff
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_load <= 1'b0;
      tx_byte <= '0;
    end else begin
      tx_load <= tx_fire;
      if (tx_fire) tx_byte <= tx_head;
    end
  end

  assign irq_rx_ovf = flags.rx_ovf && irq_en[2];
  assign irq_tx_ovf = flags.tx_ovf && irq_en[1];
  assign irq_rx_udf = flags.rx_udf && irq_en[0];
endmodule

// File: rtl/uart_fifo_buf_chk.sv
module uart_fifo_buf_chk #(
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned RX_CW    = 5,
  parameter int unsigned TX_CW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_ready,
  input logic             tx_load,
  input logic             rx_flush,
  input logic             tx_flush,
  input logic             rx_en,
  input logic [RX_CW-1:0] rx_count,
  input logic [TX_CW-1:0] tx_count,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic             ovf_en,
  input logic             irq_rx_ovf
);
  a_r4_rx_bound: assert property (@(posedge clk) disable iff (rst)
    32'(rx_count) <= RX_DEPTH);
  a_r2_legacy_one: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && rx_count <= 1) |=> (rx_en || rx_count <= 1));
  a_r9_rx_flush: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> rx_count == '0);
  a_r8_tx_flush: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> (tx_count == '0 && !tx_load));
  a_r6_load_ready: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(tx_ready));
  a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  a_r11_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_rx_ovf |-> (ovf_en && ovf_flag));
endmodule

bind uart_fifo_buf uart_fifo_buf_chk #(
  .RX_DEPTH(RX_DEPTH), .RX_CW(RX_CW), .TX_CW(TX_CW)
) u_chk (
  .clk(clk), .rst(rst), .tx_ready(tx_ready), .tx_load(tx_load),
  .rx_flush(rx_flush), .tx_flush(tx_flush), .rx_en(rx_en),
  .rx_count(rx_count), .tx_count(tx_count), .ovf_flag(flags.rx_ovf),
  .ovf_clr(wr_stat && reg_wdata[2]), .ovf_en(irq_en[2]),
  .irq_rx_ovf(irq_rx_ovf)
);

// File: tb/uart_fifo_buf_test.sv
module uart_fifo_buf_test;
  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, rx_byte = 0;
  logic rx_strobe = 0, tx_ready = 0;
  logic [7:0] reg_rdata, tx_byte;
  logic tx_load, irq_rx_ovf, irq_tx_ovf, irq_rx_udf;

  int tests = 0, fails = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] v;
  logic [7:0] last;
  bit done = 0;

  uart_fifo_buf uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  // driver: queue byte for transmit and log the expectation
  task automatic tx_send(input logic [7:0] d, input bit accepted);
    wr(2'd0, d);
    if (accepted) txq.push_back(d);
  endtask

  task automatic rx_push(input logic [7:0] d, input bit accepted);
    @(negedge clk); rx_strobe = 1; rx_byte = d;
    @(negedge clk); rx_strobe = 0;
    if (accepted) rxq.push_back(d);
  endtask

  task automatic rx_pop_check(input string req);
    logic [7:0] e;
    rd(2'd0, v);
    e = rxq.pop_front();
    chk(req, v, e);
    last = e;
  endtask

  // monitor: compare each load against the scoreboard
  always @(negedge clk) begin
    if (!rst && tx_load) begin
      tests++;
      if (txq.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected load actual=%h expected=none", tx_byte);
      end else begin
        logic [7:0] e;
        e = txq.pop_front();
        if (tx_byte !== e) begin
          fails++;
          $display("FAIL R6 actual=%h expected=%h", tx_byte, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 / R3 reset state
    rd(2'd1, v); chk("R3 mode reset", v, 8'h23);
    rd(2'd2, v); chk("R1 ctrl reset", v, 8'h00);
    rd(2'd3, v); chk("R1 status reset", v, 8'h00);
    chk("R1 irq low", {5'b0, irq_rx_ovf, irq_tx_ovf, irq_rx_udf}, 8'h00);
    chk("R1 tx_load low", {7'b0, tx_load}, 8'h00);

    // R2 legacy receive
    rx_push(8'hA1, 1);
    rx_push(8'hA2, 0);
    rd(2'd3, v); chk("R2 overrun flag", v, 8'h04);
    rx_pop_check("R2 kept word");
    // R5 underflow
    rd(2'd0, v); chk("R5 last value", v, 8'hA1);
    rd(2'd3, v); chk("R5 underflow flag", v, 8'h05);
    // R12 sticky
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R12 write 0 keeps", v, 8'h05);
    wr(2'd3, 8'h07);
    rd(2'd3, v); chk("R12 write 1 clears", v, 8'h00);

    // R3 enable FIFO mode, code unchanged
    wr(2'd1, 8'h88);
    rd(2'd1, v); chk("R3 mode enabled", v, 8'hAB);

    // R4 deep receive
    for (int i = 0; i < 16; i++) rx_push(8'(i * 3 + 1), 1);
    rd(2'd3, v); chk("R4 no overrun at depth", v, 8'h00);
    rx_push(8'hEE, 0);
    rd(2'd3, v); chk("R4 overrun flag", v, 8'h04);
    for (int i = 0; i < 16; i++) rx_pop_check("R4 order");

    // R10 / R11
    wr(2'd2, 8'hE7);
    rd(2'd2, v); chk("R10 ctrl readback", v, 8'h07);
    chk("R11 irq rx ovf on", {7'b0, irq_rx_ovf}, 8'h01);
    chk("R11 irq tx ovf off", {7'b0, irq_tx_ovf}, 8'h00);
    wr(2'd2, 8'h03);
    chk("R11 irq rx ovf gated", {7'b0, irq_rx_ovf}, 8'h00);
    wr(2'd3, 8'h07);

    // R6 / R7 transmit
    for (int i = 0; i < 8; i++) tx_send(8'(8'h40 + i), 1);
    tx_send(8'hFF, 0);
    rd(2'd3, v); chk("R7 tx overflow flag", v, 8'h02);
    chk("R11 irq tx ovf", {7'b0, irq_tx_ovf}, 8'h01);
    @(negedge clk); tx_ready = 1;
    repeat (12) @(negedge clk);
    tx_ready = 0;
    chk("R6 all delivered", 8'(txq.size()), 8'h00);
    wr(2'd3, 8'h07);

    // R8 transmit flush keeps shifter byte
    tx_send(8'h11, 1); tx_send(8'h22, 1); tx_send(8'h33, 1);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    @(negedge clk);
    wr(2'd2, 8'h80);
    txq.delete();
    chk("R8 shifter byte kept", tx_byte, 8'h11);
    @(negedge clk); tx_ready = 1;
    repeat (5) @(negedge clk);
    chk("R8 no load after flush", tx_byte, 8'h11);
    tx_send(8'h5A, 1);
    repeat (3) @(negedge clk);
    tx_ready = 0;
    chk("R8 new data after flush", tx_byte, 8'h5A);

    // R9 receive flush
    rx_push(8'h61, 1); rx_push(8'h62, 1); rx_push(8'h63, 1);
    wr(2'd2, 8'h00);
    rx_pop_check("R9 write 0 no flush");
    wr(2'd2, 8'h40);
    rxq.delete();
    rd(2'd0, v); chk("R9 flushed returns last", v, last);
    rd(2'd3, v); chk("R9 empty after flush", v, 8'h01);
    wr(2'd3, 8'h07);

    // R13 flush and push in same cycle
    @(negedge clk);
    rx_strobe = 1; rx_byte = 8'h77;
    reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'h40;
    @(negedge clk);
    rx_strobe = 0; reg_wr = 0;
    rd(2'd3, v); chk("R13 no overrun", v, 8'h00);
    rd(2'd0, v); chk("R13 flush wins", v, last);
    rd(2'd3, v); chk("R13 queue empty", v, 8'h01);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule